// File: doc/BRIEF.md
# Programmable I2C SCL Timing Generator

This block is the clock side of an I2C master. It drives the SCL line (as an open-drain pull-low enable) and tells a neighbouring byte engine when each SDA action belongs: when SDA may be changed during the low phase, when SDA is to be sampled during the high phase, and when the start and stop edges fall while SCL is high. Every interval is a count of the internal clock taken from four programmable values: the full SCL period, the low time, the setup time for start and stop edges, and the data-change delay after SCL falls.

The byte engine asks for one of three actions: a start, a data bit, or a stop. A request is taken only while the generator reports that it is ready, either idle with the bus free or parked with SCL held low between bits. The high phase is timed from the moment the sampled SCL line is actually high, so a slave that holds SCL low stretches the bit. Two control inputs model the bus-reset bits. A run enable parks the generator idle while it is low. A release input lets go of SCL at once in any phase. The four timing values are captured only while the generator is idle, so a transfer in flight is never disturbed by a change to them.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, SCL is not driven low, no strobe is active and `genReady` is 1.
- R2: A start request taken while idle raises `startEdgeStb` in the first cycle after the request. SCL stays released for `setupCount` cycles from that cycle, and then SCL is driven low and the generator parks.
- R3: A bit, stop or repeated-start request taken while parked keeps SCL low for exactly `lowCount` cycles from the cycle after the request. `sdaChangeStb` pulses once, `dataSetupCount` cycles after the first of these low cycles.
- R4: For a data bit, SCL is then released for `cycCount - lowCount` counted high cycles and driven low again, so with an unstretched line the full period is `cycCount` cycles.
- R5: `sdaSampleStb` pulses once per data bit, in the high cycle whose count is `(cycCount - lowCount) / 2` (rounded down, first high cycle counting 0).
- R6: While `sclIn` reads low after SCL has been released, the high-phase count does not advance. Every later event of that bit shifts by the number of stretched cycles.
- R7: A stop request runs the low phase and releases SCL. After `setupCount` high cycles, `stopEdgeStb` pulses in the last of them, and the generator returns to idle with SCL released. At most one strobe is active in any cycle.
- R8: A repeated-start request runs the low phase and releases SCL. After `setupCount` high cycles, `startEdgeStb` pulses in the next cycle, SCL stays high for `setupCount` cycles from that strobe, and then SCL is driven low and the generator parks.
- R9: When several requests arrive together while parked, stop wins over start and start wins over bit.
- R10: Bit and stop requests made while idle are ignored. A start request is ignored while `runEn` is 0. In both cases no strobe occurs and SCL stays released.
- R11: Asserting `sclRelease` drops the SCL pull-low in the same cycle, whatever the phase, and the generator is idle from the next cycle on.
- R12: Deasserting `runEn` suppresses all strobes. From the next cycle on, the generator is idle with SCL released.
- R13: The four timing inputs are captured only while the generator is idle. Changing them while parked or mid-bit leaves the timing of the ongoing transfer unchanged until the generator next returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycCount | input | CNT_W | Full SCL period in clock cycles |
| lowCount | input | CNT_W | SCL low time in clock cycles |
| setupCount | input | CNT_W | Setup time before a start or stop edge |
| dataSetupCount | input | CNT_W | Delay from SCL fall to the SDA change point |
| runEn | input | 1 | Normal-operation enable; 0 parks the generator idle |
| sclRelease | input | 1 | Frees SCL immediately and forces idle |
| reqStart | input | 1 | Byte-engine request: start or repeated start |
| reqBit | input | 1 | Byte-engine request: one data bit |
| reqStop | input | 1 | Byte-engine request: stop |
| sclIn | input | 1 | Sampled SCL line level |
| sclDriveLow | output | 1 | Open-drain enable: 1 pulls SCL low |
| genReady | output | 1 | Generator idle or parked, able to take a request |
| startEdgeStb | output | 1 | Drive SDA low now (SCL high) |
| stopEdgeStb | output | 1 | Release SDA now (SCL high) |
| sdaChangeStb | output | 1 | SDA may change now (SCL low) |
| sdaSampleStb | output | 1 | Sample SDA now (SCL high) |

## Verification
The embedded properties take for granted a legal programming of the counters: `lowCount` and `setupCount` at least 1, `dataSetupCount` below `lowCount`, and `cycCount` above `lowCount`. They also assume that `sclIn` reads high whenever the block does not drive low and no slave is stretching. The stimulus uses only two legal timing sets. It changes them only around idle or parked phases. A line model follows the pull-low output in the same cycle and adds a bounded stretch after release. Requests are single-cycle pulses issued only while `genReady` is high, apart from the deliberate attempts to provoke ignored requests while idle or disabled.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_PARK,
    S_LOW,
    S_HIGH,
    S_SETUP
  } tgState_e;

  typedef enum logic [1:0] {
    OP_BIT,
    OP_STOP,
    OP_RSTART
  } tgOp_e;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic loadCfg;
  } dpCtl_t;

  // datapath -> control
  typedef struct packed {
    logic cntZero;
    logic lowDone;
    logic chgHit;
    logic highDone;
    logic midHit;
    logic setupDone;
  } dpFlag_t;

endpackage

// File: rtl/scl_tg_datapath.sv
module scl_tg_datapath
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] setupCount,
  input  logic [CNT_W-1:0] dataSetupCount,
  input  dpCtl_t           ctl,
  output dpFlag_t          flags
);

  localparam int NCFG    = 4;
  localparam int IDX_CYC = 0;
  localparam int IDX_LOW = 1;
  localparam int IDX_SET = 2;
  localparam int IDX_DS  = 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfgIn [NCFG];
  logic [CNT_W-1:0] cfgQ  [NCFG];
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] midPoint;

  assign cfgIn[IDX_CYC] = cycCount;
  assign cfgIn[IDX_LOW] = lowCount;
  assign cfgIn[IDX_SET] = setupCount;
  assign cfgIn[IDX_DS]  = dataSetupCount;

  // shadow copies, refreshed only while the control reports idle
  for (genvar gi = 0; gi < NCFG; gi++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgQ[gi] <= '0;
      end else if (ctl.loadCfg) begin
        cfgQ[gi] <= cfgIn[gi];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (ctl.cntClr) begin
      phaseCnt <= '0;
    end else if (ctl.cntEn) begin
      phaseCnt <= phaseCnt + ONE;
    end
  end

  assign highLen  = cfgQ[IDX_CYC] - cfgQ[IDX_LOW];
  assign midPoint = highLen >> 1;

  always_comb begin
    flags.cntZero   = (phaseCnt == '0);
    flags.lowDone   = (phaseCnt == cfgQ[IDX_LOW] - ONE);
    flags.chgHit    = (phaseCnt == cfgQ[IDX_DS]);
    flags.highDone  = (phaseCnt == highLen - ONE);
    flags.midHit    = (phaseCnt == midPoint);
    flags.setupDone = (phaseCnt == cfgQ[IDX_SET] - ONE);
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cntEn && !ctl.cntClr) |-> (phaseCnt != '1)); // R4

endmodule

// File: rtl/scl_tg_control.sv
module scl_tg_control
  import scl_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    runEn,
  input  logic    sclRelease,
  input  logic    reqStart,
  input  logic    reqBit,
  input  logic    reqStop,
  input  logic    sclIn,
  input  dpFlag_t flags,
  output dpCtl_t  ctl,
  output logic    sclDriveLow,
  output logic    genReady,
  output logic    startEdgeStb,
  output logic    stopEdgeStb,
  output logic    sdaChangeStb,
  output logic    sdaSampleStb
);

  tgState_e state;
  tgState_e stateNxt;
  tgOp_e    opQ;
  tgOp_e    opNxt;
  logic     go;

  assign go = runEn && !sclRelease;

  always_comb begin
    stateNxt = state;
    opNxt    = opQ;
    unique case (state)
      S_IDLE: begin
        if (reqStart) stateNxt = S_HOLD;
      end
      S_HOLD: begin
        if (flags.setupDone) stateNxt = S_PARK;
      end
      S_PARK: begin
        if (reqStop) begin
          stateNxt = S_LOW;
          opNxt    = OP_STOP;
        end else if (reqStart) begin
          stateNxt = S_LOW;
          opNxt    = OP_RSTART;
        end else if (reqBit) begin
          stateNxt = S_LOW;
          opNxt    = OP_BIT;
        end
      end
      S_LOW: begin
        if (flags.lowDone) stateNxt = (opQ == OP_BIT) ? S_HIGH : S_SETUP;
      end
      S_HIGH: begin
        if (flags.highDone && sclIn) stateNxt = S_PARK;
      end
      S_SETUP: begin
        if (flags.setupDone && sclIn) stateNxt = (opQ == OP_STOP) ? S_IDLE : S_HOLD;
      end
      default: stateNxt = S_IDLE;
    endcase
    if (!go) stateNxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      opQ   <= OP_BIT;
    end else begin
      state <= stateNxt;
      opQ   <= opNxt;
    end
  end

  // strobes to the datapath
  always_comb begin
    ctl.cntClr  = (stateNxt != state);
    ctl.loadCfg = (state == S_IDLE);
    unique case (state)
      S_LOW, S_HOLD:    ctl.cntEn = 1'b1;
      S_HIGH, S_SETUP:  ctl.cntEn = sclIn;
      default:          ctl.cntEn = 1'b0;
    endcase
  end

  assign sclDriveLow  = ((state == S_PARK) || (state == S_LOW)) && !sclRelease;
  assign genReady     = (state == S_IDLE) || (state == S_PARK);
  assign startEdgeStb = go && (state == S_HOLD) && flags.cntZero;
  assign stopEdgeStb  = go && (state == S_SETUP) && (opQ == OP_STOP) &&
                        flags.setupDone && sclIn;
  assign sdaChangeStb = go && (state == S_LOW) && flags.chgHit;
  assign sdaSampleStb = go && (state == S_HIGH) && flags.midHit && sclIn;

  AST_PARK_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (sclRelease || !runEn) |=> (state == S_IDLE)); // R12

  AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sdaSampleStb |-> (sclIn && !sclDriveLow)); // R5

  AST_CHANGE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdaChangeStb |-> sclDriveLow); // R3

  AST_EDGE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (startEdgeStb || stopEdgeStb) |-> !sclDriveLow); // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({startEdgeStb, stopEdgeStb, sdaChangeStb, sdaSampleStb})); // R7

  AST_LOW_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_HIGH) && ($past(state) == S_LOW)) |-> $past(flags.lowDone)); // R3

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] setupCount,
  input  logic [CNT_W-1:0] dataSetupCount,
  input  logic             runEn,
  input  logic             sclRelease,
  input  logic             reqStart,
  input  logic             reqBit,
  input  logic             reqStop,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             genReady,
  output logic             startEdgeStb,
  output logic             stopEdgeStb,
  output logic             sdaChangeStb,
  output logic             sdaSampleStb
);

  dpCtl_t  dpCtl;
  dpFlag_t dpFlags;

  scl_tg_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk            (clk),
    .rst_n          (rst_n),
    .cycCount       (cycCount),
    .lowCount       (lowCount),
    .setupCount     (setupCount),
    .dataSetupCount (dataSetupCount),
    .ctl            (dpCtl),
    .flags          (dpFlags)
  );

  scl_tg_control u_control (
    .clk          (clk),
    .rst_n        (rst_n),
    .runEn        (runEn),
    .sclRelease   (sclRelease),
    .reqStart     (reqStart),
    .reqBit       (reqBit),
    .reqStop      (reqStop),
    .sclIn        (sclIn),
    .flags        (dpFlags),
    .ctl          (dpCtl),
    .sclDriveLow  (sclDriveLow),
    .genReady     (genReady),
    .startEdgeStb (startEdgeStb),
    .stopEdgeStb  (stopEdgeStb),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb)
  );

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CNT_W = 16;
  localparam int EV_START = 0, EV_STOP = 1, EV_CHG = 2, EV_SMP = 3, EV_FALL = 4, EV_RISE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cycCount, lowCount, setupCount, dataSetupCount;
  logic runEn = 1'b1, sclRelease = 1'b0;
  logic reqStart = 1'b0, reqBit = 1'b0, reqStop = 1'b0;
  logic sclIn;
  logic sclDriveLow, genReady, startEdgeStb, stopEdgeStb, sdaChangeStb, sdaSampleStb;

  int cycN = 0;
  int stA = -1, stLen = 0;
  int checkCnt = 0, failCnt = 0, evCount = 0;
  int aCyc, aLow, aSet, aDs;
  bit done = 1'b0;

  int    expKind[$];
  int    expCyc[$];
  string expReq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cycN <= cycN + 1;

  // line model: pulled up unless driven low or held by a stretching slave
  assign sclIn = !sclDriveLow && !(cycN >= stA && cycN < stA + stLen);

  scl_timing_gen #(.CNT_W(CNT_W)) u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .cycCount(cycCount), .lowCount(lowCount),
    .setupCount(setupCount), .dataSetupCount(dataSetupCount), .runEn(runEn),
    .sclRelease(sclRelease), .reqStart(reqStart), .reqBit(reqBit), .reqStop(reqStop),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .genReady(genReady),
    .startEdgeStb(startEdgeStb), .stopEdgeStb(stopEdgeStb),
    .sdaChangeStb(sdaChangeStb), .sdaSampleStb(sdaSampleStb)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycN);
    end
  endtask

  task automatic pushEv(int k, int c, string r);
    expKind.push_back(k);
    expCyc.push_back(c);
    expReq.push_back(r);
  endtask

  task automatic observe(int k);
    int ek, ec;
    string er;
    evCount++;
    if (expKind.size() == 0) begin
      check(1'b0, "unexpected event", k, -1);
    end else begin
      ek = expKind.pop_front();
      ec = expCyc.pop_front();
      er = expReq.pop_front();
      check(ek == k, {er, " event kind"}, k, ek);
      check(ec == cycN, {er, " event cycle"}, cycN, ec);
    end
  endtask

  // monitor: scoreboard side
  logic prevLow = 1'b0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (startEdgeStb) observe(EV_START);
      if (stopEdgeStb)  observe(EV_STOP);
      if (sdaChangeStb) observe(EV_CHG);
      if (sdaSampleStb) observe(EV_SMP);
      if (sclDriveLow && !prevLow) observe(EV_FALL);
      if (!sclDriveLow && prevLow) observe(EV_RISE);
      prevLow = sclDriveLow;
    end
  end

  task automatic waitUntil(int c);
    while (cycN <= c) @(negedge clk);
  endtask

  task automatic pulseReq(bit s, bit b, bit p);
    reqStart = s; reqBit = b; reqStop = p;
    @(negedge clk);
    reqStart = 1'b0; reqBit = 1'b0; reqStop = 1'b0;
  endtask

  task automatic setCfg(int c, int l, int s, int d);
    cycCount = CNT_W'(c); lowCount = CNT_W'(l);
    setupCount = CNT_W'(s); dataSetupCount = CNT_W'(d);
  endtask

  task automatic doStart();
    int n = cycN;
    pushEv(EV_START, n + 1, "R2");
    pushEv(EV_FALL, n + aSet + 1, "R2");
    pulseReq(1, 0, 0);
    waitUntil(n + aSet + 1);
  endtask

  task automatic doBit(int s);
    int n = cycN;
    if (s > 0) begin stA = n + aLow + 1; stLen = s; end
    pushEv(EV_CHG, n + 1 + aDs, "R3");
    pushEv(EV_RISE, n + aLow + 1, "R3");
    pushEv(EV_SMP, n + aLow + 1 + s + (aCyc - aLow) / 2, s > 0 ? "R6" : "R5");
    pushEv(EV_FALL, n + aCyc + 1 + s, s > 0 ? "R6" : "R4");
    pulseReq(0, 1, 0);
    waitUntil(n + aCyc + 1 + s);
    stLen = 0;
  endtask

  task automatic doStop(bit alsoStart);
    int n = cycN;
    pushEv(EV_CHG, n + 1 + aDs, "R3");
    pushEv(EV_RISE, n + aLow + 1, "R7");
    pushEv(EV_STOP, n + aLow + aSet, alsoStart ? "R9" : "R7");
    pulseReq(alsoStart, 0, 1);
    waitUntil(n + aLow + aSet + 1);
  endtask

  task automatic doRestart(bit alsoBit);
    int n = cycN;
    pushEv(EV_CHG, n + 1 + aDs, "R3");
    pushEv(EV_RISE, n + aLow + 1, "R8");
    pushEv(EV_START, n + aLow + aSet + 1, alsoBit ? "R9" : "R8");
    pushEv(EV_FALL, n + aLow + 2 * aSet + 1, "R8");
    pulseReq(1, alsoBit, 0);
    waitUntil(n + aLow + 2 * aSet + 1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finishRun();
    end
  end

  initial begin
    int n, snap;
    setCfg(20, 10, 10, 1);
    aCyc = 20; aLow = 10; aSet = 10; aDs = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(sclDriveLow == 1'b0, "R1 scl released", int'(sclDriveLow), 0);
    check({startEdgeStb, stopEdgeStb, sdaChangeStb, sdaSampleStb} == 4'b0, "R1 strobes", 1, 0);
    check(genReady == 1'b1, "R1 ready", int'(genReady), 1);
    @(negedge clk);

    doStart();
    doBit(0);
    doBit(4);
    doBit(0);
    doStop(0);

    // R10: bit and stop while idle are ignored
    snap = evCount;
    pulseReq(0, 1, 0);
    pulseReq(0, 0, 1);
    repeat (30) @(negedge clk);
    #1;
    check(evCount == snap, "R10 idle requests ignored", evCount, snap);
    check(sclDriveLow == 1'b0, "R10 scl stays released", int'(sclDriveLow), 0);
    @(negedge clk);

    doStart();
    doRestart(1);
    // R13: change timing while parked; ongoing transfer keeps old values
    setCfg(26, 14, 6, 3);
    doBit(0);
    doStop(1);
    aCyc = 26; aLow = 14; aSet = 6; aDs = 3;
    doStart();
    doBit(0);
    doBit(3);
    doStop(0);

    // R11: release in the middle of a low phase
    doStart();
    n = cycN;
    pushEv(EV_CHG, n + 1 + aDs, "R3");
    pushEv(EV_RISE, n + 5, "R11");
    pulseReq(0, 1, 0);
    waitUntil(n + 4);
    sclRelease = 1'b1;
    @(negedge clk);
    #1;
    check(genReady == 1'b1, "R11 idle after release", int'(genReady), 1);
    check(sclDriveLow == 1'b0, "R11 scl released", int'(sclDriveLow), 0);
    @(negedge clk);
    sclRelease = 1'b0;
    @(negedge clk);

    // R12: drop run enable in the middle of a low phase
    doStart();
    n = cycN;
    pushEv(EV_CHG, n + 1 + aDs, "R3");
    pushEv(EV_RISE, n + 6, "R12");
    pulseReq(0, 1, 0);
    waitUntil(n + 4);
    runEn = 1'b0;
    repeat (3) @(negedge clk);
    snap = evCount;
    pulseReq(1, 0, 0);
    repeat (20) @(negedge clk);
    #1;
    check(evCount == snap, "R10 start ignored while disabled", evCount, snap);
    check(genReady == 1'b1, "R12 parked idle", int'(genReady), 1);
    @(negedge clk);
    runEn = 1'b1;
    @(negedge clk);

    doStart();
    doBit(0);
    doStop(0);

    repeat (5) @(negedge clk);
    check(expKind.size() == 0, "all expected events seen", expKind.size(), 0);
    done = 1'b1;
    finishRun();
  end

endmodule